// File: doc/BRIEF.md
# SD/MMC Command Issue and Response Capture

This block sends a single card command to a card-side byte interface and collects the card's reply into four 32-bit response words. Software-facing logic writes an 11-bit command control word together with a 32-bit argument. When the enable bit is set and the block is idle, the block offers the command index and argument to the card side, then waits for a length header or a no-reply strobe. It drains exactly the announced number of reply bytes and finishes with exactly one of three one-cycle status pulses: reply captured, command sent (no reply wanted), or timeout.

Reply bytes are packed big-endian: the first byte of each group of four lands in bits 31:24 of its word. A 4-byte reply fills word 0 and zeroes the other three. A 16-byte reply fills all four words, and the lowest bit of the last word is forced to zero. Any unusable reply length is reported as a timeout and not as a separate error. The interrupt-mode and pending-command options are not supported. A command that requests either one ends in a timeout without reaching the card.

Top module: `sdcmd_capture`

## Requirements
- R1: After an accepted start, `req_valid` is high with `req_index` equal to control bits 5:0 and `req_arg` equal to the argument written with it, until `req_ready` is seen at a clock edge.
- R2: Control word bit 10 is the enable. The stored copy on `ctl_q` keeps that bit set while the command is in flight and clears it automatically when the command ends, whatever the outcome.
- R3: With bit 6 (reply expected) clear, a header of any length, including 0, is followed by that many drained bytes and then ends with `evt_sent`.
- R4: With bit 6 set, a 0-byte header, a 4-byte header while bit 7 (long reply) is set, or a `no_reply` strobe (in either mode) ends with `evt_timeout`.
- R5: With bit 6 set, any header length other than 4 or 16 ends with `evt_timeout` after all announced bytes have been drained on `byte_ready`/`byte_valid`.
- R6: Each response word holds its four bytes big-endian: the earliest received byte is in bits 31:24 and the fourth is in bits 7:0. Word 0 is `resp_words[31:0]` and word k is `resp_words[32k+31:32k]`.
- R7: A 4-byte reply clears words 1 to 3. A 16-byte reply fills all four words with bit 0 of word 3 forced to 0, and it is accepted whether or not bit 7 is set.
- R8: A successful capture raises `evt_resp_end` for one cycle. `resp_words` change in that cycle and in no other.
- R9: A start with bit 8 (interrupt mode) or bit 9 (pending) set raises no card request, and ends with `evt_timeout` in the second cycle after the write.
- R10: `busy` rises in the cycle after an accepted start and stays high through the single cycle of its one status pulse. Control writes while busy are ignored.
- R11: A control write with bit 10 clear while idle updates `ctl_q` but starts nothing.
- R12: After reset, `busy`, `ctl_q`, `resp_words`, all handshake outputs and all status pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 11 | Control word: index 5:0, reply 6, long 7, interrupt 8, pending 9, enable 10 |
| cmd_arg | input | ARG_W | Command argument, latched at start |
| ctl_q | output | 11 | Stored control word; bit 10 clears at command end |
| busy | output | 1 | Command in flight |
| req_valid | output | 1 | Command offered to the card side |
| req_ready | input | 1 | Card side takes the command |
| req_index | output | 6 | Command index offered |
| req_arg | output | ARG_W | Argument offered |
| hdr_ready | output | 1 | Block waits for a length header or no-reply strobe |
| hdr_valid | input | 1 | Length header present |
| hdr_len | input | LEN_W | Reply length in bytes |
| no_reply | input | 1 | Card gives no reply; takes priority over hdr_valid |
| byte_ready | output | 1 | Block accepts reply bytes |
| byte_valid | input | 1 | Reply byte present |
| byte_data | input | 8 | Reply byte |
| resp_words | output | N_WORDS*WORD_W | Response words, word 0 in the low bits |
| evt_resp_end | output | 1 | One-cycle pulse: reply captured |
| evt_sent | output | 1 | One-cycle pulse: command sent, no reply wanted |
| evt_timeout | output | 1 | One-cycle pulse: no usable reply or unsupported option |

## Verification
The hardest situation to reach from the ports is a control write that lands while a command is parked waiting for its header. Only a card side that holds back its header opens that window. The bench's card model stalls for several cycles after taking the command and pokes a new enabled control word into that gap. It then checks that `ctl_q`, the request and the final outcome all belong to the first command. Stale responses are checked the same way: a long request answered with four bytes must leave the earlier 16-byte capture untouched on `resp_words`.

// File: rtl/sdcr_pkg.sv
package sdcr_pkg;

   // control word layout (field positions decoded by the controller)
   localparam int CW_W   = 11;
   localparam int IDX_W  = 6;
   localparam int B_EXP  = 6;
   localparam int B_LONG = 7;
   localparam int B_INTR = 8;
   localparam int B_PEND = 9;
   localparam int B_EN   = 10;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ISSUE,
      S_LEN,
      S_DATA,
      S_FIN
   } st_t;

   typedef enum logic [1:0] {
      O_NONE,
      O_SENT,
      O_RESP,
      O_TMO
   } outc_t;

endpackage

// File: rtl/sdcr_ctrl.sv
module sdcr_ctrl
   import sdcr_pkg::*;
#(
   parameter int ARG_W     = 32,
   parameter int LEN_W     = 5,
   parameter int SHORT_LEN = 4,
   parameter int LONG_LEN  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CW_W-1:0]  ctl_word,
   input  logic [ARG_W-1:0] cmd_arg,
   input  logic             req_ready,
   input  logic             hdr_valid,
   input  logic [LEN_W-1:0] hdr_len,
   input  logic             no_reply,
   input  logic             byte_valid,
   output logic [CW_W-1:0]  ctl_q,
   output logic             busy,
   output logic             req_valid,
   output logic [ARG_W-1:0] req_arg,
   output logic             hdr_ready,
   output logic             byte_ready,
   output logic             evt_resp_end,
   output logic             evt_sent,
   output logic             evt_timeout,
   output logic             buf_clr,
   output logic             buf_shift,
   output logic             buf_commit,
   output logic             buf_long
);

   localparam logic [LEN_W-1:0] L_SHORT = LEN_W'(SHORT_LEN);
   localparam logic [LEN_W-1:0] L_LONG  = LEN_W'(LONG_LEN);
   localparam logic [LEN_W-1:0] L_ONE   = LEN_W'(1);

   st_t              st, st_d;
   outc_t            outc, outc_d;
   logic [CW_W-1:0]  cw;
   logic [ARG_W-1:0] arg_q;
   logic [LEN_W-1:0] len_q, cnt;
   logic             start, unsup, last_byte, hdr_take;

   function automatic outc_t judge(input logic expect_rsp, input logic want_long,
                                   input logic [LEN_W-1:0] n);
      if (!expect_rsp)
         return O_SENT;
      else if ((n == L_SHORT && !want_long) || n == L_LONG)
         return O_RESP;
      else
         return O_TMO;
   endfunction

   assign start     = (st == S_IDLE) && ctl_wr && ctl_word[B_EN];
   assign unsup     = ctl_word[B_INTR] | ctl_word[B_PEND];
   assign last_byte = (st == S_DATA) && byte_valid && (cnt == L_ONE);
   assign hdr_take  = (st == S_LEN) && hdr_valid && !no_reply && (hdr_len != '0);

   always_comb begin
      st_d   = st;
      outc_d = outc;
      case (st)
         S_IDLE:
            if (start) begin
               if (unsup) begin
                  st_d   = S_FIN;
                  outc_d = O_TMO;
               end else begin
                  st_d   = S_ISSUE;
               end
            end
         S_ISSUE:
            if (req_ready) st_d = S_LEN;
         S_LEN:
            if (no_reply) begin
               st_d   = S_FIN;
               outc_d = O_TMO;
            end else if (hdr_valid) begin
               if (hdr_len == '0) begin
                  st_d   = S_FIN;
                  outc_d = cw[B_EXP] ? O_TMO : O_SENT;
               end else begin
                  st_d   = S_DATA;
               end
            end
         S_DATA:
            if (last_byte) begin
               st_d   = S_FIN;
               outc_d = judge(cw[B_EXP], cw[B_LONG], len_q);
            end
         S_FIN:
            st_d = S_IDLE;
         default:
            st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         outc  <= O_NONE;
         cw    <= '0;
         arg_q <= '0;
         len_q <= '0;
         cnt   <= '0;
      end else begin
         st   <= st_d;
         outc <= outc_d;
         if (st == S_IDLE && ctl_wr)
            cw <= ctl_word;
         else if (st == S_FIN)
            cw[B_EN] <= 1'b0;
         if (start)
            arg_q <= cmd_arg;
         if (hdr_take) begin
            len_q <= hdr_len;
            cnt   <= hdr_len;
         end else if (st == S_DATA && byte_valid) begin
            cnt <= cnt - L_ONE;
         end
      end
   end

   assign ctl_q        = cw;
   assign busy         = (st != S_IDLE);
   assign req_valid    = (st == S_ISSUE);
   assign req_arg      = arg_q;
   assign hdr_ready    = (st == S_LEN);
   assign byte_ready   = (st == S_DATA);
   assign evt_resp_end = (st == S_FIN) && (outc == O_RESP);
   assign evt_sent     = (st == S_FIN) && (outc == O_SENT);
   assign evt_timeout  = (st == S_FIN) && (outc == O_TMO);
   assign buf_clr      = start;
   assign buf_shift    = (st == S_DATA) && byte_valid;
   assign buf_commit   = last_byte && (outc_d == O_RESP);
   assign buf_long     = (len_q == L_LONG);

endmodule

// File: rtl/sdcr_assemble.sv
module sdcr_assemble #(
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 4,
   parameter int BYTE_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      shift_en,
   input  logic [BYTE_W-1:0]         byte_in,
   input  logic                      commit,
   input  logic                      commit_long,
   output logic [N_WORDS*WORD_W-1:0] resp_words
);

   localparam int BUF_W = N_WORDS * WORD_W;
   localparam logic [BUF_W-1:0] LAST_LSB =
      {{(BUF_W-1){1'b0}}, 1'b1} << ((N_WORDS - 1) * WORD_W);

   logic [BUF_W-1:0] sh, sh_d, long_img, short_img, words_q;

   always_comb begin
      if (clr)
         sh_d = '0;
      else if (shift_en)
         sh_d = {sh[BUF_W-BYTE_W-1:0], byte_in};
      else
         sh_d = sh;
   end

   // earliest bytes sit at the top of the shifter: word k comes from slot k from the top
   for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      assign long_img[k*WORD_W +: WORD_W] = sh_d[BUF_W-1-k*WORD_W -: WORD_W];
   end

   assign short_img = {{(BUF_W-WORD_W){1'b0}}, sh_d[WORD_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh      <= '0;
         words_q <= '0;
      end else begin
         sh <= sh_d;
         if (commit)
            words_q <= commit_long ? (long_img & ~LAST_LSB) : short_img;
      end
   end

   assign resp_words = words_q;

endmodule

// File: rtl/sdcmd_capture.sv
module sdcmd_capture
   import sdcr_pkg::*;
#(
   parameter int ARG_W   = 32,
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 4,
   parameter int LEN_W   = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ctl_wr,
   input  logic [10:0]               ctl_word,
   input  logic [ARG_W-1:0]          cmd_arg,
   output logic [10:0]               ctl_q,
   output logic                      busy,
   output logic                      req_valid,
   input  logic                      req_ready,
   output logic [5:0]                req_index,
   output logic [ARG_W-1:0]          req_arg,
   output logic                      hdr_ready,
   input  logic                      hdr_valid,
   input  logic [LEN_W-1:0]          hdr_len,
   input  logic                      no_reply,
   output logic                      byte_ready,
   input  logic                      byte_valid,
   input  logic [7:0]                byte_data,
   output logic [N_WORDS*WORD_W-1:0] resp_words,
   output logic                      evt_resp_end,
   output logic                      evt_sent,
   output logic                      evt_timeout
);

   localparam int BYTE_W    = 8;
   localparam int SHORT_LEN = WORD_W / BYTE_W;
   localparam int LONG_LEN  = SHORT_LEN * N_WORDS;

   if (WORD_W % BYTE_W != 0) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (N_WORDS < 2) begin : g_bad_words
      $error("N_WORDS must be at least 2");
   end
   if ((1 << LEN_W) <= LONG_LEN) begin : g_bad_len
      $error("LEN_W too narrow for a long reply length");
   end

   logic buf_clr, buf_shift, buf_commit, buf_long;

   sdcr_ctrl #(
      .ARG_W    (ARG_W),
      .LEN_W    (LEN_W),
      .SHORT_LEN(SHORT_LEN),
      .LONG_LEN (LONG_LEN)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .ctl_word    (ctl_word),
      .cmd_arg     (cmd_arg),
      .req_ready   (req_ready),
      .hdr_valid   (hdr_valid),
      .hdr_len     (hdr_len),
      .no_reply    (no_reply),
      .byte_valid  (byte_valid),
      .ctl_q       (ctl_q),
      .busy        (busy),
      .req_valid   (req_valid),
      .req_arg     (req_arg),
      .hdr_ready   (hdr_ready),
      .byte_ready  (byte_ready),
      .evt_resp_end(evt_resp_end),
      .evt_sent    (evt_sent),
      .evt_timeout (evt_timeout),
      .buf_clr     (buf_clr),
      .buf_shift   (buf_shift),
      .buf_commit  (buf_commit),
      .buf_long    (buf_long)
   );

   assign req_index = ctl_q[IDX_W-1:0];

   sdcr_assemble #(
      .WORD_W (WORD_W),
      .N_WORDS(N_WORDS),
      .BYTE_W (BYTE_W)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (buf_clr),
      .shift_en   (buf_shift),
      .byte_in    (byte_data),
      .commit     (buf_commit),
      .commit_long(buf_long),
      .resp_words (resp_words)
   );

endmodule

// File: rtl/sdcr_checker.sv
module sdcr_checker #(
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [10:0]               ctl_q,
   input logic                      busy,
   input logic                      req_valid,
   input logic                      hdr_ready,
   input logic                      byte_ready,
   input logic [N_WORDS*WORD_W-1:0] resp_words,
   input logic                      evt_resp_end,
   input logic                      evt_sent,
   input logic                      evt_timeout
);

   logic any_evt;
   assign any_evt = evt_resp_end | evt_sent | evt_timeout;

   p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_resp_end, evt_sent, evt_timeout}));

   p_event_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |-> busy);

   p_busy_ends_on_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(any_evt));

   p_enable_tracks_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[10] == busy);

   p_req_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy);

   p_one_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_valid, hdr_ready, byte_ready}));

   p_resp_moves_on_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(resp_words) |-> evt_resp_end);

   p_last_lsb_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_words[(N_WORDS-1)*WORD_W] == 1'b0);

endmodule

bind sdcmd_capture sdcr_checker #(
   .WORD_W (WORD_W),
   .N_WORDS(N_WORDS)
) u_sdcr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_q       (ctl_q),
   .busy        (busy),
   .req_valid   (req_valid),
   .hdr_ready   (hdr_ready),
   .byte_ready  (byte_ready),
   .resp_words  (resp_words),
   .evt_resp_end(evt_resp_end),
   .evt_sent    (evt_sent),
   .evt_timeout (evt_timeout)
);

// File: tb/sdcmd_capture_bench.sv
module sdcmd_capture_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 100000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctl_wr = 1'b0;
   logic [10:0]  ctl_word = '0;
   logic [31:0]  cmd_arg = '0;
   logic         req_ready = 1'b0;
   logic         hdr_valid = 1'b0;
   logic [4:0]   hdr_len = '0;
   logic         no_reply = 1'b0;
   logic         byte_valid = 1'b0;
   logic [7:0]   byte_data = '0;
   logic [10:0]  ctl_q;
   logic         busy, req_valid, hdr_ready, byte_ready;
   logic [5:0]   req_index;
   logic [31:0]  req_arg;
   logic [127:0] resp_words;
   logic         evt_resp_end, evt_sent, evt_timeout;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdcmd_capture u_sdcmd_capture (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word), .cmd_arg(cmd_arg),
      .ctl_q(ctl_q), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
      .req_index(req_index), .req_arg(req_arg), .hdr_ready(hdr_ready),
      .hdr_valid(hdr_valid), .hdr_len(hdr_len), .no_reply(no_reply),
      .byte_ready(byte_ready), .byte_valid(byte_valid), .byte_data(byte_data),
      .resp_words(resp_words), .evt_resp_end(evt_resp_end), .evt_sent(evt_sent),
      .evt_timeout(evt_timeout)
   );

   int n_cmp = 0, n_bad = 0;
   int n_sent = 0, n_resp = 0, n_tmo = 0, n_req = 0;
   int s_sent, s_resp, s_tmo, s_req;
   int cyc = 0;
   bit done = 0;

   task automatic check(input string tag, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: phase 0 idle, 1 offer, 2 header wait, 3 bytes, 4 finish
   int           ph = 0, m_out = 0, m_len = 0, m_cnt = 0;
   logic [10:0]  m_cw = '0;
   logic [31:0]  m_arg = '0;
   logic [127:0] m_w = '0;
   logic [7:0]   q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; m_out = 0; m_cw = '0; m_arg = '0; m_w = '0; q.delete();
      end else begin
         case (ph)
            0: if (ctl_wr) begin
                  m_cw = ctl_word;
                  if (ctl_word[10]) begin
                     m_arg = cmd_arg;
                     q.delete();
                     if (ctl_word[8] || ctl_word[9]) begin m_out = 3; ph = 4; end
                     else ph = 1;
                  end
               end
            1: if (req_ready) ph = 2;
            2: if (no_reply) begin m_out = 3; ph = 4; end
               else if (hdr_valid) begin
                  m_len = int'(hdr_len);
                  if (m_len == 0) begin m_out = m_cw[6] ? 3 : 1; ph = 4; end
                  else begin m_cnt = m_len; ph = 3; end
               end
            3: if (byte_valid) begin
                  q.push_back(byte_data);
                  m_cnt--;
                  if (m_cnt == 0) begin
                     ph = 4;
                     if (!m_cw[6]) m_out = 1;
                     else if ((m_len == 4 && !m_cw[7]) || m_len == 16) begin
                        m_out = 2;
                        m_w = '0;
                        if (m_len == 4)
                           m_w[31:0] = {q[0], q[1], q[2], q[3]};
                        else begin
                           for (int k = 0; k < 4; k++)
                              m_w[32*k +: 32] = {q[4*k], q[4*k+1], q[4*k+2], q[4*k+3]};
                           m_w[96] = 1'b0;
                        end
                     end else m_out = 3;
                  end
               end
            4: begin ph = 0; m_cw[10] = 1'b0; end
            default: ph = 0;
         endcase
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R10", "busy", 128'(busy), 128'(ph != 0));
         check("R2", "ctl_q", 128'(ctl_q), 128'(m_cw));
         check("R1", "req_valid", 128'(req_valid), 128'(ph == 1));
         if (ph == 1) begin
            check("R1", "req_index", 128'(req_index), 128'(m_cw[5:0]));
            check("R1", "req_arg", 128'(req_arg), 128'(m_arg));
         end
         check("R5", "hdr_ready", 128'(hdr_ready), 128'(ph == 2));
         check("R5", "byte_ready", 128'(byte_ready), 128'(ph == 3));
         check("R8", "evt_resp_end", 128'(evt_resp_end), 128'(ph == 4 && m_out == 2));
         check("R3", "evt_sent", 128'(evt_sent), 128'(ph == 4 && m_out == 1));
         check("R4", "evt_timeout", 128'(evt_timeout), 128'(ph == 4 && m_out == 3));
         check("R6", "resp_words", resp_words, m_w);
         if (evt_sent) n_sent++;
         if (evt_resp_end) n_resp++;
         if (evt_timeout) n_tmo++;
         if (req_valid) n_req++;
      end
   end

   task automatic snap();
      s_sent = n_sent; s_resp = n_resp; s_tmo = n_tmo; s_req = n_req;
   endtask

   task automatic outcome(input string tag, input int ds, input int dr, input int dt);
      check(tag, "sent pulses", 128'(n_sent - s_sent), 128'(ds));
      check(tag, "capture pulses", 128'(n_resp - s_resp), 128'(dr));
      check(tag, "timeout pulses", 128'(n_tmo - s_tmo), 128'(dt));
   endtask

   task automatic run(input logic [10:0] cw, input logic [31:0] arg, input bit silent,
                      input int len, input logic [7:0] b0, input logic [7:0] step,
                      input bit gaps, input bit poke);
      snap();
      @(negedge clk);
      ctl_wr = 1'b1; ctl_word = cw; cmd_arg = arg;
      @(negedge clk);
      ctl_wr = 1'b0;
      if (cw[8] || cw[9]) begin
         repeat (4) @(negedge clk);
         return;
      end
      while (!req_valid) @(negedge clk);
      check("R1", "offered index", 128'(req_index), 128'(cw[5:0]));
      check("R1", "offered argument", 128'(req_arg), 128'(arg));
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      if (poke) begin
         repeat (2) @(negedge clk);
         ctl_wr = 1'b1; ctl_word = 11'h4C3; cmd_arg = 32'hDEAD_BEEF;
         @(negedge clk);
         ctl_wr = 1'b0;
         check("R10", "ctl_q after write while busy", 128'(ctl_q), 128'(cw));
         repeat (2) @(negedge clk);
      end
      while (!hdr_ready) @(negedge clk);
      if (silent) no_reply = 1'b1;
      else begin hdr_valid = 1'b1; hdr_len = 5'(len); end
      @(negedge clk);
      no_reply = 1'b0; hdr_valid = 1'b0;
      if (!silent) begin
         for (int i = 0; i < len; i++) begin
            byte_valid = 1'b1;
            byte_data = b0 + 8'(i) * step;
            @(negedge clk);
            if (gaps && (i % 2 == 0)) begin
               byte_valid = 1'b0;
               byte_data = 8'h5A;
               @(negedge clk);
            end
         end
         byte_valid = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG && !done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R12: reset state
      check("R12", "busy at reset", 128'(busy), 128'(0));
      check("R12", "ctl_q at reset", 128'(ctl_q), 128'(0));
      check("R12", "resp at reset", resp_words, 128'(0));
      check("R12", "pulses at reset", 128'({evt_resp_end, evt_sent, evt_timeout, req_valid}), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R11: write without enable
      snap();
      ctl_wr = 1'b1; ctl_word = 11'h0C5; cmd_arg = 32'h1;
      @(negedge clk);
      ctl_wr = 1'b0;
      repeat (4) @(negedge clk);
      check("R11", "ctl_q stored", 128'(ctl_q), 128'(11'h0C5));
      check("R11", "no start", 128'(busy), 128'(0));
      check("R11", "no request", 128'(n_req - s_req), 128'(0));

      // R3: no reply wanted
      run(11'h400, 32'h0000_0000, 0, 0, 8'h00, 8'h00, 0, 0);
      outcome("R3", 1, 0, 0);
      run(11'h411, 32'h1234_5678, 0, 4, 8'h01, 8'h01, 1, 0);
      outcome("R3", 1, 0, 0);

      // R6/R7: short capture
      run(11'h451, 32'hCAFE_0001, 0, 4, 8'h11, 8'h11, 0, 0);
      outcome("R8", 0, 1, 0);
      check("R6", "short word 0", resp_words, {96'h0, 32'h11223344});

      // R7: long capture with odd final byte
      run(11'h4C2, 32'h0000_00AA, 0, 16, 8'hA0, 8'h01, 1, 0);
      outcome("R8", 0, 1, 0);
      check("R7", "long words", resp_words,
            {32'hACADAEAE, 32'hA8A9AAAB, 32'hA4A5A6A7, 32'hA0A1A2A3});

      // R4: long requested, 4 given; previous capture must persist
      run(11'h4C3, 32'h2, 0, 4, 8'h55, 8'h01, 0, 0);
      outcome("R4", 0, 0, 1);
      check("R8", "resp kept after timeout", resp_words,
            {32'hACADAEAE, 32'hA8A9AAAB, 32'hA4A5A6A7, 32'hA0A1A2A3});
      run(11'h444, 32'h3, 0, 0, 8'h00, 8'h00, 0, 0);
      outcome("R4", 0, 0, 1);
      run(11'h445, 32'h4, 1, 0, 8'h00, 8'h00, 0, 0);
      outcome("R4", 0, 0, 1);
      run(11'h406, 32'h5, 1, 0, 8'h00, 8'h00, 0, 0);
      outcome("R4", 0, 0, 1);

      // R5: odd length drained then timeout
      run(11'h447, 32'h6, 0, 7, 8'h30, 8'h03, 1, 0);
      outcome("R5", 0, 0, 1);

      // R7: 16 bytes accepted on a short request
      run(11'h448, 32'h7, 0, 16, 8'h10, 8'h10, 0, 0);
      outcome("R7", 0, 1, 0);
      check("R7", "16 on short", resp_words,
            {32'hD0E0F000, 32'h90A0B0C0, 32'h50607080, 32'h10203040});

      // R9: unsupported options
      run(11'h509, 32'h8, 0, 0, 8'h00, 8'h00, 0, 0);
      outcome("R9", 0, 0, 1);
      check("R9", "no request (interrupt)", 128'(n_req - s_req), 128'(0));
      run(11'h60A, 32'h9, 0, 0, 8'h00, 8'h00, 0, 0);
      outcome("R9", 0, 0, 1);
      check("R9", "no request (pending)", 128'(n_req - s_req), 128'(0));

      // R10: write landing while waiting for header
      run(11'h44B, 32'h0000_0B0B, 0, 4, 8'hF1, 8'h01, 0, 1);
      outcome("R10", 0, 1, 0);
      check("R10", "capture of first command", resp_words, {96'h0, 32'hF1F2F3F4});
      check("R2", "enable cleared", 128'(ctl_q), 128'(11'h04B));

      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule